// File: doc/BRIEF.md
# SMBus Word-Write Slave with Snoop Capture

This block listens on a two-wire SMBus segment as a receiver and answers word-write transactions aimed at one of two programmable addresses. The first, the own address, is 7-bit or 10-bit, chosen by a mode input. The second, the spy address, is always 7-bit. A word write is made of a start condition, the address byte with the write bit, a command byte, a low data byte, a high data byte and a stop condition. Each byte is followed by an acknowledge slot.

The two addresses fill the capture registers differently. A hit on the spy address keeps the command byte together with the data word. A hit on the own address keeps the address that was received together with the data word. Each address has a pending flag. The flag is raised when the matched frame ends with a stop condition, or when the clock is held low for too long after the match. A one-cycle event pulse marks every raise, so it can be used as an interrupt or a wake-up. While either flag is pending, the block leaves the acknowledge slot after any new address byte undriven, so unread captures are never overwritten. Software clears each flag with its own clear strobe.

Both bus lines pass through a two-stage synchroniser before edges, start conditions and stop conditions are detected. The block drives SDA only as an open-drain pull-down.

Top module: `smbus_snoop_slave`

## Requirements
- R1: A write to the spy address is acknowledged for the address byte, the command byte and both data bytes. The address byte is the 7-bit address followed by a 0 in bit 0. cap_word becomes {8'h00, command}. data_word becomes {second data byte, first data byte}.
- R2: In 7-bit mode (own_ten_bit = 0), a write to own_addr[6:0] is acknowledged for all four bytes. cap_word becomes {8'h00, own_addr[6:0], 1'b0}. The command byte is acknowledged but not stored. data_word is filled as in R1.
- R3: In 10-bit mode, the first byte is 11110, then own_addr[9:8], then a write bit of 0, and it is acknowledged. The second byte must equal own_addr[7:0]. Only then is the match complete and cap_word = {first byte[7:1], second byte, 1'b0}. If the second byte differs, it is not acknowledged and nothing is captured.
- R4: After a match, the pending flag of the matched address rises only once the stop condition is seen. It stays low during the bytes.
- R5: After a match, if SCL stays low for TIMEOUT_CYC cycles without a rising edge, the matched pending flag is set, SDA is released and the frame is abandoned.
- R6: While own_pend or spy_pend is set, no address byte is acknowledged, and cap_word and data_word stay unchanged.
- R7: An address byte that matches neither address, or that has bit 0 = 1 (read), is not acknowledged and changes nothing.
- R8: Bytes after the second data byte are not acknowledged. The flag still rises at the stop condition.
- R9: clr_own clears own_pend and clr_spy clears spy_pend.
- R10: evt_pulse is high for exactly one cycle each time a pending flag is set.
- R11: After reset, the pending flags, capture registers and evt_pulse are 0 and SDA is released.
- R12: The SDA pull-down starts after the SCL falling edge that ends the eighth bit. It is released after the SCL falling edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SMBus clock line as seen on the bus |
| sda_in | input | 1 | SMBus data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 10 | Own address; bits 6:0 in 7-bit mode, 9:0 in 10-bit mode |
| own_ten_bit | input | 1 | 1 selects 10-bit addressing for the own address |
| spy_addr | input | 7 | 7-bit snoop address |
| clr_own | input | 1 | Clears own_pend |
| clr_spy | input | 1 | Clears spy_pend |
| cap_word | output | 16 | Captured command (spy hit) or address (own hit) |
| data_word | output | 16 | Captured data word, high byte received last |
| own_pend | output | 1 | Own-address capture waiting to be read |
| spy_pend | output | 1 | Spy-address capture waiting to be read |
| evt_pulse | output | 1 | One-cycle pulse when a pending flag is set |

## Verification
The bench builds the block with TIMEOUT_CYC = 300 instead of a timeout of several milliseconds. This lets a clock stretched in the middle of an acknowledge run into the timeout within a few hundred cycles. The bench can then see the release of SDA and the flag raised with no stop condition. SYNC_STAGES keeps its default of two, so the bench master holds each half bit for 16 cycles. That leaves enough margin after the synchroniser for acknowledge sampling, and it puts capture updates a few cycles after each SCL edge, where the per-cycle model comparison expects them.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_SKIP
    } bus_st_e;

    typedef enum logic [2:0] {
        PH_ADR,
        PH_ADR2,
        PH_CMD,
        PH_DLO,
        PH_DHI,
        PH_OVER
    } phase_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_OWN,
        HIT_SPY
    } hit_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic        ack;
        phase_e      ph;
        hit_e        hit;
        logic        cap_we;
        logic [15:0] cap_v;
        logic        first_we;
        logic        lo_we;
        logic        hi_we;
    } dec_t;

    localparam logic [4:0] TEN_BIT_HDR = 5'b11110;

    function automatic logic is_ten_hdr(input logic [7:0] b);
        return b[7:3] == TEN_BIT_HDR;
    endfunction

endpackage

// File: rtl/smbs_line_sync.sv
module smbs_line_sync
    import smbs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    localparam int CW = 2 * SYNC_STAGES;

    logic [CW-1:0] chain;
    logic [1:0]    cur;
    logic [1:0]    prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 2'b11;
        end else begin
            chain <= {chain[CW-3:0], sda_in, scl_in};
            prev  <= cur;
        end
    end

    assign cur = chain[CW-1:CW-2];

    always_comb begin
        ev.scl      = cur[0];
        ev.sda      = cur[1];
        ev.scl_rise = cur[0] & ~prev[0];
        ev.scl_fall = ~cur[0] & prev[0];
        ev.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
        ev.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
    end

    a_r12_start_stop_excl: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));

endmodule

// File: rtl/smbs_tmo.sv
module smbs_tmo #(
    parameter int LIMIT = 3000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == CW'(LIMIT));

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));

    a_r5_kick_clears: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0));

endmodule

// File: rtl/smbs_flags.sv
module smbs_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sts,
    output logic         evt
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                sts[g] <= 1'b0;
            end else if (set[g]) begin
                sts[g] <= 1'b1;
            end else if (clr[g]) begin
                sts[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= |set;
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    a_r10_pulse_with_rise: assert property (@(posedge clk) disable iff (rst)
        evt |-> ($countones(sts & ~$past(sts)) == 1));

endmodule

// File: rtl/smbus_snoop_slave.sv
module smbus_snoop_slave
    import smbs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 3000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull,
    input  logic [9:0]  own_addr,
    input  logic        own_ten_bit,
    input  logic [6:0]  spy_addr,
    input  logic        clr_own,
    input  logic        clr_spy,
    output logic [15:0] cap_word,
    output logic [15:0] data_word,
    output logic        own_pend,
    output logic        spy_pend,
    output logic        evt_pulse
);
    localparam int BITS = 8;

    line_ev_t   ev;
    bus_st_e    st;
    phase_e     ph;
    hit_e       hit;
    logic [7:0] sh;
    logic [3:0] bcnt;
    logic [6:0] first_q;
    logic       tmo_expire;
    logic       pend;
    logic [1:0] set_v;
    logic [1:0] sts_v;
    logic       byte_end;
    dec_t       dec;

    smbs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smbs_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .run    ((hit != HIT_NONE) && !ev.scl),
        .kick   (ev.scl_rise),
        .expire (tmo_expire)
    );

    assign set_v[0] = (tmo_expire || ev.stop) && (hit == HIT_OWN);
    assign set_v[1] = (tmo_expire || ev.stop) && (hit == HIT_SPY);

    smbs_flags #(.N(2)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (set_v),
        .clr ({clr_spy, clr_own}),
        .sts (sts_v),
        .evt (evt_pulse)
    );

    assign own_pend = sts_v[0];
    assign spy_pend = sts_v[1];
    assign pend     = |sts_v;
    assign byte_end = (st == ST_RX) && ev.scl_fall && (bcnt == 4'(BITS));

    // Byte decode: acknowledge decision and capture writes per phase
    always_comb begin
        dec = '0;
        dec.ph  = PH_OVER;
        dec.hit = hit;
        case (ph)
            PH_ADR: begin
                if (!pend && !sh[0]) begin
                    if (own_ten_bit && is_ten_hdr(sh) && sh[2:1] == own_addr[9:8]) begin
                        dec.ack      = 1'b1;
                        dec.ph       = PH_ADR2;
                        dec.first_we = 1'b1;
                    end else if (!own_ten_bit && sh[7:1] == own_addr[6:0]) begin
                        dec.ack    = 1'b1;
                        dec.ph     = PH_CMD;
                        dec.hit    = HIT_OWN;
                        dec.cap_we = 1'b1;
                        dec.cap_v  = {8'h00, sh[7:1], 1'b0};
                    end else if (sh[7:1] == spy_addr) begin
                        dec.ack = 1'b1;
                        dec.ph  = PH_CMD;
                        dec.hit = HIT_SPY;
                    end
                end
            end
            PH_ADR2: begin
                if (sh == own_addr[7:0]) begin
                    dec.ack    = 1'b1;
                    dec.ph     = PH_CMD;
                    dec.hit    = HIT_OWN;
                    dec.cap_we = 1'b1;
                    dec.cap_v  = {first_q, sh, 1'b0};
                end
            end
            PH_CMD: begin
                dec.ack    = 1'b1;
                dec.ph     = PH_DLO;
                dec.cap_we = (hit == HIT_SPY);
                dec.cap_v  = {8'h00, sh};
            end
            PH_DLO: begin
                dec.ack   = 1'b1;
                dec.ph    = PH_DHI;
                dec.lo_we = 1'b1;
            end
            PH_DHI: begin
                dec.ack   = 1'b1;
                dec.ph    = PH_OVER;
                dec.hi_we = 1'b1;
            end
            default: dec.ack = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_ADR;
            hit       <= HIT_NONE;
            sh        <= '0;
            bcnt      <= '0;
            first_q   <= '0;
            sda_pull  <= 1'b0;
            cap_word  <= '0;
            data_word <= '0;
        end else if (tmo_expire || ev.stop) begin
            st       <= ST_IDLE;
            hit      <= HIT_NONE;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_RX;
            ph       <= PH_ADR;
            hit      <= HIT_NONE;
            bcnt     <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (ev.scl_rise && bcnt < 4'(BITS)) begin
                        sh   <= {sh[6:0], ev.sda};
                        bcnt <= bcnt + 1'b1;
                    end else if (byte_end) begin
                        if (dec.ack) begin
                            st       <= ST_ACK;
                            sda_pull <= 1'b1;
                            ph       <= dec.ph;
                            hit      <= dec.hit;
                            if (dec.cap_we)   cap_word        <= dec.cap_v;
                            if (dec.first_we) first_q         <= sh[7:1];
                            if (dec.lo_we)    data_word[7:0]  <= sh;
                            if (dec.hi_we)    data_word[15:8] <= sh;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        sda_pull <= 1'b0;
                        st       <= ST_RX;
                        bcnt     <= '0;
                    end
                end
                default: st <= st;
            endcase
        end
    end

    a_r12_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(ev.scl_fall));

    a_r12_release_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> $past(ev.scl_fall || ev.stop || ev.start || tmo_expire));

    a_r4_own_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(own_pend) |-> $past(ev.stop || tmo_expire));

    a_r4_spy_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(spy_pend) |-> $past(ev.stop || tmo_expire));

    a_r6_holdoff_nack: assert property (@(posedge clk) disable iff (rst)
        (byte_end && ph == PH_ADR && pend) |=> !sda_pull);

    a_r6_capture_frozen: assert property (@(posedge clk) disable iff (rst)
        (pend && $past(pend)) |-> ($stable(cap_word) && $stable(data_word)));

    a_r5_release_on_timeout: assert property (@(posedge clk) disable iff (rst)
        tmo_expire |=> !sda_pull);

endmodule

// File: tb/smbus_snoop_slave_tb.sv
module smbus_snoop_slave_tb;
    localparam int TMO = 300;
    localparam int H   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_pull;
    logic [9:0]  own_addr = 10'h05A;
    logic        own_ten_bit = 1'b0;
    logic [6:0]  spy_addr = 7'h2C;
    logic        clr_own = 1'b0;
    logic        clr_spy = 1'b0;
    logic [15:0] cap_word;
    logic [15:0] data_word;
    logic        own_pend;
    logic        spy_pend;
    logic        evt_pulse;
    wire         bus_sda = m_sda & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] e_cap = '0;
    logic [15:0] e_data = '0;
    bit    e_own = 0;
    bit    e_spy = 0;
    int    e_evt = 0;
    int    got_evt = 0;
    int    mph = -1;
    int    mkind = 0;
    logic [6:0] mfirst = '0;
    int    settle = 0;
    bit    cmp_on = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    smbus_snoop_slave #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(bus_sda),
        .sda_pull(sda_pull), .own_addr(own_addr), .own_ten_bit(own_ten_bit),
        .spy_addr(spy_addr), .clr_own(clr_own), .clr_spy(clr_spy),
        .cap_word(cap_word), .data_word(data_word), .own_pend(own_pend),
        .spy_pend(spy_pend), .evt_pulse(evt_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (evt_pulse) got_evt++;
            if (settle > 0) settle--;
            else if (cmp_on) begin
                chk(cap_word == e_cap, cur_req, "cap_word", int'(cap_word), int'(e_cap));
                chk(data_word == e_data, cur_req, "data_word", int'(data_word), int'(e_data));
                chk(own_pend == e_own, cur_req, "own_pend", int'(own_pend), int'(e_own));
                chk(spy_pend == e_spy, cur_req, "spy_pend", int'(spy_pend), int'(e_spy));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_byte(input logic [7:0] b, output bit ack);
        ack = 0;
        if (mph == 0) begin
            if (!(e_own || e_spy) && b[0] == 1'b0) begin
                if (own_ten_bit && b[7:3] == 5'b11110 && b[2:1] == own_addr[9:8]) begin
                    ack = 1; mph = 1; mfirst = b[7:1];
                end else if (!own_ten_bit && b[7:1] == own_addr[6:0]) begin
                    ack = 1; mph = 2; mkind = 1; e_cap = {8'h00, b[7:1], 1'b0};
                end else if (b[7:1] == spy_addr) begin
                    ack = 1; mph = 2; mkind = 2;
                end
            end
        end else if (mph == 1) begin
            if (b == own_addr[7:0]) begin
                ack = 1; mph = 2; mkind = 1; e_cap = {mfirst, b, 1'b0};
            end
        end else if (mph == 2) begin
            ack = 1; mph = 3;
            if (mkind == 2) e_cap = {8'h00, b};
        end else if (mph == 3) begin
            ack = 1; mph = 4; e_data[7:0] = b;
        end else if (mph == 4) begin
            ack = 1; mph = 5; e_data[15:8] = b;
        end
        if (!ack) mph = -1;
        settle = 8;
    endtask

    task automatic model_end();
        if (mkind == 1) begin e_own = 1; e_evt++; end
        if (mkind == 2) begin e_spy = 1; e_evt++; end
        mkind = 0; mph = -1; settle = 8;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H);
        m_sda = 1'b0; mph = 0; mkind = 0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H);
        m_sda = 1'b1; model_end(); tick(2 * H);
    endtask

    task automatic send_bits(input logic [7:0] b, output bit exp_ack);
        exp_ack = 0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
            if (i == 0) model_byte(b, exp_ack);
        end
        tick(H);
        m_sda = 1'b1;
    endtask

    task automatic xfer(input logic [7:0] b, input string req);
        bit exp_ack;
        bit got_ack;
        send_bits(b, exp_ack);
        tick(H);
        m_scl = 1'b1; tick(H / 2);
        got_ack = (bus_sda == 1'b0);
        chk(got_ack == exp_ack, req, $sformatf("ack for byte %0h", b), int'(got_ack), int'(exp_ack));
        tick(H / 2);
        m_scl = 1'b0; tick(H);
        chk(sda_pull == 1'b0, "R12", "pull released after ack clock", int'(sda_pull), 0);
    endtask

    task automatic pulse_clr(input bit own, input string req);
        @(negedge clk);
        if (own) begin clr_own = 1'b1; e_own = 0; end
        else     begin clr_spy = 1'b1; e_spy = 0; end
        settle = 3;
        @(negedge clk);
        clr_own = 1'b0; clr_spy = 1'b0;
        tick(4);
        chk(own ? !own_pend : !spy_pend, req, "flag cleared", own ? int'(own_pend) : int'(spy_pend), 0);
    endtask

    initial begin
        bit a;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        chk(sda_pull == 1'b0, "R11", "sda_pull", int'(sda_pull), 0);
        chk(cap_word == 16'h0, "R11", "cap_word", int'(cap_word), 0);
        chk(data_word == 16'h0, "R11", "data_word", int'(data_word), 0);
        chk(!own_pend && !spy_pend, "R11", "pending", int'({own_pend, spy_pend}), 0);
        chk(!evt_pulse, "R11", "evt_pulse", int'(evt_pulse), 0);
        cmp_on = 1;

        // R1 spy word write, R4 flag only at stop, R10 pulse
        cur_req = "R1";
        bus_start();
        xfer(8'h58, "R1"); xfer(8'hA5, "R1"); xfer(8'h34, "R1"); xfer(8'h12, "R1");
        chk(!spy_pend, "R4", "spy flag before stop", int'(spy_pend), 0);
        cur_req = "R4";
        bus_stop();
        chk(cap_word == 16'h00A5 && data_word == 16'h1234, "R1", "capture",
            int'({cap_word, data_word}), 32'h00A5_1234);
        chk(got_evt == 1, "R10", "event count", got_evt, 1);

        // R6 hold-off while spy flag pending
        cur_req = "R6";
        bus_start();
        xfer(8'hB4, "R6");
        bus_stop();
        bus_start();
        xfer(8'h58, "R6");
        bus_stop();
        chk(cap_word == 16'h00A5 && !own_pend, "R6", "capture held",
            int'({own_pend, cap_word}), 16'h00A5);

        // R9 clear
        cur_req = "R9";
        pulse_clr(1'b0, "R9");

        // R2 own 7-bit, R8 extra byte
        cur_req = "R2";
        bus_start();
        xfer(8'hB4, "R2"); xfer(8'h77, "R2"); xfer(8'hEF, "R2"); xfer(8'hBE, "R2");
        xfer(8'h55, "R8");
        bus_stop();
        chk(cap_word == 16'h00B4 && data_word == 16'hBEEF && own_pend, "R2", "own capture",
            int'({cap_word, data_word}), 32'h00B4_BEEF);
        chk(got_evt == e_evt, "R10", "event count", got_evt, e_evt);
        pulse_clr(1'b1, "R9");

        // R7 mismatch and read bit
        cur_req = "R7";
        bus_start(); xfer(8'h20, "R7"); bus_stop();
        bus_start(); xfer(8'h59, "R7"); bus_stop();
        chk(!own_pend && !spy_pend && cap_word == 16'h00B4, "R7", "no change",
            int'({own_pend, spy_pend, cap_word}), 16'h00B4);

        // R3 10-bit own address
        cur_req = "R3";
        own_ten_bit = 1'b1; own_addr = 10'h2C5;
        tick(4);
        bus_start();
        xfer(8'hF4, "R3"); xfer(8'hC5, "R3"); xfer(8'h01, "R3");
        xfer(8'h78, "R3"); xfer(8'h56, "R3");
        bus_stop();
        chk(cap_word == 16'hF58A && data_word == 16'h5678, "R3", "10-bit capture",
            int'({cap_word, data_word}), 32'hF58A_5678);
        pulse_clr(1'b1, "R9");
        bus_start();
        xfer(8'hF4, "R3"); xfer(8'hC6, "R3");
        bus_stop();
        chk(!own_pend && cap_word == 16'hF58A, "R3", "second byte mismatch",
            int'({own_pend, cap_word}), 16'hF58A);

        // R5 timeout while acknowledging
        cur_req = "R5";
        own_ten_bit = 1'b0; own_addr = 10'h05A;
        tick(4);
        bus_start();
        xfer(8'h58, "R5"); xfer(8'h11, "R5");
        send_bits(8'h22, a);
        tick(H);
        chk(sda_pull == 1'b1, "R12", "pull during stretched ack", int'(sda_pull), 1);
        model_end();
        settle = TMO + 40;
        tick(TMO + 24);
        chk(sda_pull == 1'b0, "R5", "released after timeout", int'(sda_pull), 0);
        chk(spy_pend == 1'b1, "R5", "flag after timeout", int'(spy_pend), 1);
        chk(cap_word == 16'h0011 && data_word == 16'h5622, "R5", "partial capture",
            int'({cap_word, data_word}), 32'h0011_5622);
        bus_stop();
        chk(got_evt == e_evt, "R10", "event count", got_evt, e_evt);
        pulse_clr(1'b0, "R9");
        tick(20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule